// File: doc/BRIEF.md
# GPIO Port with Edge Interrupt

This block is an 8-bit general-purpose I/O port for a small microcontroller. Software reaches it over a plain register bus (address, write strobe, write data, combinational read data). Six registers control it: the output value, the direction, the pull-up enable, the input-path enable, the edge mode of the interrupt pin, and the interrupt status. Each bit of the port drives a pad through an output value and an output enable. Each pad sends back an input level, and the block also sends a pull-up request to the pad.

Pad levels pass through a two-flop synchronizer. A pin whose input-path enable is cleared is cut off from the read path and reads as 1, whatever the pad does. One pin, chosen by a parameter, feeds an edge detector. The edge mode selects both edges, rising only, falling only, or none. The detector sets a sticky interrupt flag that software clears by writing 1 to the status register. Any input pin with its path enabled raises a wake pulse when its synchronized level toggles.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset these registers read 0x00: output value, direction, pull-up enable, edge mode (both edges) and status. The input-path enable reads 0xFF.
- R2: The registers sit at these addresses: 0 data, 1 direction, 2 pull-up enable, 3 input-path enable, 4 edge mode in bits [1:0] (upper bits read 0), 5 status with the flag in bit 0 (upper bits read 0). A write takes effect at the next clock edge, and addresses 0 to 4 read back what was written. Reading address 0 follows R3 and R4.
- R3: Reading address 0 returns, for an input pin (direction bit 0), the pad level after a two-clock synchronizer. If that pin's input-path enable bit is 0, the bit reads 1 instead, whatever level is on the pad.
- R4: A pin whose direction bit is 1 has pad_oe set and drives pad_out with its data bit. Reading address 0 returns the data register bit for that pin. When the direction bit is 0, pad_oe is 0.
- R5: pad_pu for a pin is 1 exactly when its pull-up bit is 1 and its direction bit is 0.
- R6: wake is high during any cycle in which an input pin with its input-path enable bit at 1 shows a change between its synchronized level and that level one clock earlier.
- R7: The interrupt pin's edge mode selects 00 both edges, 01 rising only, 10 falling only, 11 none. An edge counts only while that pin's input-path enable bit is 1. A qualifying edge sets irq two clock edges after the pad change has been captured.
- R8: irq stays set until software writes address 5 with bit 0 at 1. If a qualifying edge is found in the same cycle as that write, irq stays set.
- R9: The edge mode can be rewritten while irq is set. The new mode applies from the next clock, and each edge after it that qualifies sets irq again once the flag has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up requests |
| wake | output | 1 | Wake event from a toggling enabled input |
| irq | output | 1 | Sticky interrupt request flag |

## Verification
A register write is visible on the read data and pad outputs one clock edge after the strobe is sampled. A pad change shows up on the read data after two edges, on wake during the window between the second and third edges, and on irq after the third edge. The bench keeps a behavioural model that holds a queue of pad samples. The model advances at each rising edge and is compared with every output at each falling edge, so every result is checked in the cycle in which it is due. Acknowledge writes are swept across several offsets around an edge, so that one of them lands in the same cycle as a detected edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_DIR  = 3'd1,
        REG_PULL = 3'd2,
        REG_DIEN = 3'd3,
        REG_EMOD = 3'd4,
        REG_STAT = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        EDGE_BOTH = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_OFF  = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic logic edge_hit(edge_mode_e mode, edge_ev_t ev);
        case (mode)
            EDGE_BOTH: return ev.rise | ev.fall;
            EDGE_RISE: return ev.rise;
            EDGE_FALL: return ev.fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      pull_q,
    output logic [W-1:0]      dien_q,
    output edge_mode_e        emod_q,
    output logic              ack
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '0;
            pull_q <= '0;
            dien_q <= '1;
            emod_q <= EDGE_BOTH;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                REG_DATA: out_q  <= wdata;
                REG_DIR:  dir_q  <= wdata;
                REG_PULL: pull_q <= wdata;
                REG_DIEN: dien_q <= wdata;
                REG_EMOD: emod_q <= edge_mode_e'(wdata[1:0]);
                default:  ;
            endcase
        end
    end

    assign ack = wr_en && (reg_addr_e'(addr) == REG_STAT) && wdata[0];

    // R1
    reset_dien_chk: assert property (@(posedge clk) rst |=> (dien_q == '1));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] stage [STAGES+1];

    assign stage[0] = d;

    for (genvar s = 1; s <= STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_prev <= '0;
        else     q_prev <= stage[STAGES];
    end

    assign q = stage[STAGES];

    // R3
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (q_prev == $past(q)));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_port_pkg::*;
#(
    parameter int W   = 8,
    parameter int PIN = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] lvl_prev,
    input  logic [W-1:0] dien,
    input  edge_mode_e   mode,
    input  logic         ack,
    output logic         flag
);
    edge_ev_t ev;
    logic     hit;

    always_comb begin
        ev.rise = dien[PIN] &  lvl[PIN] & ~lvl_prev[PIN];
        ev.fall = dien[PIN] & ~lvl[PIN] &  lvl_prev[PIN];
        hit     = edge_hit(mode, ev);
    end

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= (flag & ~ack) | hit;
    end

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !ack) |=> flag);
    // R8
    ack_edge_keep_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag);
    // R7
    mode_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == EDGE_OFF && !flag) |=> !flag);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W       = 8,
    parameter int IRQ_PIN = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_pu,
    output logic              wake,
    output logic              irq
);
    logic [W-1:0] out_q, dir_q, pull_q, dien_q, lvl, lvl_prev, rd_pins;
    edge_mode_e   emod_q;
    logic         ack;

    gpio_regs #(.W(W)) i_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .out_q(out_q), .dir_q(dir_q), .pull_q(pull_q), .dien_q(dien_q),
        .emod_q(emod_q), .ack(ack)
    );

    gpio_sync #(.W(W), .STAGES(2)) i_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(lvl), .q_prev(lvl_prev)
    );

    gpio_edge_irq #(.W(W), .PIN(IRQ_PIN)) i_irq (
        .clk(clk), .rst(rst), .lvl(lvl), .lvl_prev(lvl_prev), .dien(dien_q),
        .mode(emod_q), .ack(ack), .flag(irq)
    );

    for (genvar b = 0; b < W; b++) begin : g_pin
        always_comb begin
            if (dir_q[b])       rd_pins[b] = out_q[b];
            else if (dien_q[b]) rd_pins[b] = lvl[b];
            else                rd_pins[b] = 1'b1;
        end
    end

    always_comb begin
        case (reg_addr_e'(bus_addr))
            REG_DATA: bus_rdata = rd_pins;
            REG_DIR:  bus_rdata = dir_q;
            REG_PULL: bus_rdata = pull_q;
            REG_DIEN: bus_rdata = dien_q;
            REG_EMOD: bus_rdata = {{(W-2){1'b0}}, emod_q};
            REG_STAT: bus_rdata = {{(W-1){1'b0}}, irq};
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;
    assign pad_pu  = pull_q & ~dir_q;
    assign wake    = |((lvl ^ lvl_prev) & ~dir_q & dien_q);

    // R4
    dir_write_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_DIR) |=> (pad_oe == $past(bus_wdata)));
    // R3
    gated_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_DATA && dien_q == '0 && dir_q == '0) |-> (bus_rdata == '1));
    // R6
    wake_input_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> ((~dir_q & dien_q) != '0));
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] bus_rdata, pad_out, pad_oe, pad_pu;
    logic       wake, irq;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .wake(wake), .irq(irq)
    );

    // Behavioural reference model
    logic [7:0] m_out, m_dir, m_pull, m_dien;
    logic [1:0] m_mode;
    logic       m_flag;
    logic [7:0] hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_out = 0; m_dir = 0; m_pull = 0; m_dien = 8'hFF; m_mode = 0; m_flag = 0;
            hist = '{8'h00, 8'h00, 8'h00};
        end else if (hist.size() == 3) begin
            bit cur, old, rise, fall, hit, ack;
            cur  = hist[1][0];
            old  = hist[2][0];
            rise = m_dien[0] && cur && !old;
            fall = m_dien[0] && !cur && old;
            hit  = (m_mode == 0) ? (rise || fall) : (m_mode == 1) ? rise :
                   (m_mode == 2) ? fall : 1'b0;
            ack  = bus_wr && bus_addr == 3'd5 && bus_wdata[0];
            m_flag = (m_flag && !ack) || hit;
            if (bus_wr) begin
                if (bus_addr == 3'd0) m_out  = bus_wdata;
                if (bus_addr == 3'd1) m_dir  = bus_wdata;
                if (bus_addr == 3'd2) m_pull = bus_wdata;
                if (bus_addr == 3'd3) m_dien = bus_wdata;
                if (bus_addr == 3'd4) m_mode = bus_wdata[1:0];
            end
            hist.push_front(pad_in);
            void'(hist.pop_back());
        end
    end

    function automatic logic [7:0] exp_rdata();
        logic [7:0] r;
        case (bus_addr)
            3'd0: for (int b = 0; b < 8; b++)
                      r[b] = m_dir[b] ? m_out[b] : (m_dien[b] ? hist[1][b] : 1'b1);
            3'd1: r = m_dir;
            3'd2: r = m_pull;
            3'd3: r = m_dien;
            3'd4: r = {6'b0, m_mode};
            3'd5: r = {7'b0, m_flag};
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (hist.size() == 3 && !done) begin
            check("R1 R2 R3 R4 rdata", bus_rdata, exp_rdata());
            check("R4 pad_out", pad_out, m_out);
            check("R4 pad_oe", pad_oe, m_dir);
            check("R5 pad_pu", pad_pu, m_pull & ~m_dir);
            check("R6 wake", {7'b0, wake},
                  {7'b0, |((hist[1] ^ hist[2]) & ~m_dir & m_dien)});
            check("R7 R8 R9 irq", {7'b0, irq}, {7'b0, m_flag});
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_wr = 0;
    endtask

    task automatic look(logic [2:0] a, int n);
        bus_addr = a;
        step(n);
    endtask

    task automatic pin0(logic v);
        pad_in[0] = v;
        step(4);
    endtask

    initial begin
        step(3);
        rst = 0;
        // R1: reset values on every address
        for (int a = 0; a < 6; a++) look(a[2:0], 1);
        // R2 R3: input reads with synchronizer latency
        look(3'd0, 1);
        foreach (pad_in[i]) begin pad_in = 8'h1 << i; step(1); end
        pad_in = 8'hA5; step(3);
        pad_in = 8'h5A; step(3);
        // R3: path disabled reads 1
        wr(3'd3, 8'h0F); look(3'd0, 1);
        pad_in = 8'h00; step(3);
        wr(3'd3, 8'h00); look(3'd0, 2);
        pad_in = 8'hFF; step(3);
        wr(3'd3, 8'hFF); look(3'd0, 3);
        // R4: outputs driven, read back register value
        wr(3'd0, 8'h3C); wr(3'd1, 8'hF0); look(3'd0, 2);
        pad_in = 8'h00; step(3);
        // R5: pull-up only on inputs
        wr(3'd2, 8'hFF); look(3'd2, 2);
        wr(3'd1, 8'h00); step(2);
        for (int a = 0; a < 5; a++) look(a[2:0], 1);
        // R6: wake on enabled inputs only
        wr(3'd1, 8'h0F); pad_in = 8'h01; step(4);
        pad_in = 8'h81; step(4);
        wr(3'd3, 8'hFE); pad_in = 8'h82; step(4);
        wr(3'd3, 8'hFF); wr(3'd1, 8'h00);
        // R7: each edge mode on pin 0
        look(3'd5, 1);
        for (int m = 0; m < 4; m++) begin
            wr(3'd4, m[7:0]);
            pin0(1); wr(3'd5, 8'h01); step(2);
            pin0(0); wr(3'd5, 8'h01); step(2);
        end
        wr(3'd4, 8'h00); wr(3'd3, 8'h00);
        pin0(1); pin0(0); wr(3'd3, 8'hFF); wr(3'd5, 8'h01); step(3);
        // R8: acknowledge swept across the edge cycle
        for (int off = 0; off < 5; off++) begin
            pin0(~pad_in[0]); wr(3'd5, 8'h01);
            pad_in[0] = ~pad_in[0];
            step(off);
            wr(3'd5, 8'h01);
            step(3);
            wr(3'd5, 8'h01); step(1);
        end
        // R9: change mode while flag is set, later edges still caught
        wr(3'd4, 8'h01); pin0(0); pin0(1);
        wr(3'd4, 8'h02); wr(3'd5, 8'h01); step(1);
        pin0(0); pin0(1); wr(3'd5, 8'h01); step(1);
        pin0(0); step(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            compared++; mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule